// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller gathers 64 level-sensitive interrupt sources and turns them into two active-high requests: a normal request and a fast request. Each source has an enable bit, a type bit that steers it to one of the two requests, a software force bit, and a 4-bit priority. Software reaches all of this state through a simple word-addressed register bus: address, write strobe, write data, and a combinational read-data port.

Sources are enabled or disabled one at a time by writing a source number to a set register or a clear register. The whole enable state can also be written as two words. The priority fields are packed eight to a word. For the normal request, a 5-bit mask level filters out low priorities. Two vector registers name the winning pending source, so a handler can branch to it without scanning the pending words.

Top module: `vpic_top`

## Requirements
- R1: After reset, the enable, type, force and priority registers and the mask register read zero, both request outputs are low, and both vector registers read 0xFFFFFFFF.
- R2: Writing a value n below 64 to offset 0x08 sets only enable bit n. A value of 64 or more leaves every enable bit unchanged.
- R3: Writing a value n below 64 to offset 0x0C clears only enable bit n. Every other enable bit keeps its value.
- R4: The enable bits for sources 63..32 are read and written at offset 0x10, and those for sources 31..0 at offset 0x14. Bit k of a word belongs to source k or to source 32+k.
- R5: The type bits sit at 0x18 (high word) and 0x1C (low word). A type bit of 1 routes the source only to the fast request, and 0 routes it only to the normal request.
- R6: The priority of source n is bits [4*(n%8)+3 : 4*(n%8)] of group n/8. Group g is read and written at offset 0x20 + 4*(7-g).
- R7: The mask register at 0x04 holds 5 bits. A normal source is pending only if its priority is strictly above mask bits [3:0], except that while mask bit 4 is set no priority is masked.
- R8: A source requests when its input is high or its force bit is set. Force words are at 0x50 (high) and 0x54 (low). Offsets 0x48 and 0x4C return the raw input levels, without the force bits.
- R9: The normal-pending words (0x58 high, 0x5C low) show the sources that are requesting, enabled, of type 0 and unmasked. The fast-pending words (0x60 high, 0x64 low) show the sources that are requesting, enabled and of type 1.
- R10: Offset 0x40 returns the normal-pending source with the highest priority in bits [31:16] and its priority in bits [15:0]. On a tie the higher source number wins. With nothing pending it reads 0xFFFFFFFF.
- R11: Offset 0x44 returns the highest-numbered fast-pending source in bits [31:16] and zero in bits [15:0]. With nothing pending it reads 0xFFFFFFFF.
- R12: The normal request output is high in the cycle after any normal-pending bit is set, and the fast request output is high in the cycle after any fast-pending bit is set. Each output is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| src_i | input | 64 | Level-sensitive interrupt inputs |
| irq_norm_o | output | 1 | Registered normal request |
| irq_fast_o | output | 1 | Registered fast request |

## Verification
The directed cases isolate one mechanism at a time:
- Enabling a source by number, including out-of-range numbers, shows whether the decoder touches neighbouring bits or wraps large numbers.
- Two enabled sources with equal priority show the tie-break direction.
- A mask level equal to a source's priority, then one below it, shows whether the comparison is strict. Mask bit 4 with a priority-0 source shows the override.
- A force bit with the input low shows that force reaches pending but not the raw status word.

Random sparse inputs are then mixed with random enable, type, force, priority and mask writes. This exercises routing, the packing of the priority groups in reverse order, and arbitration among many pending sources at once.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int MASK_W = 5;

  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_ENNUM  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_DISNUM = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_ENH    = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_ENL    = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_TYPH   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_TYPL   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_PRIO   = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_NVEC   = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_FVEC   = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_SRCH   = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_SRCL   = 8'h4C;
  localparam logic [ADDR_W-1:0] OFF_FRCH   = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_FRCL   = 8'h54;
  localparam logic [ADDR_W-1:0] OFF_NPH    = 8'h58;
  localparam logic [ADDR_W-1:0] OFF_NPL    = 8'h5C;
  localparam logic [ADDR_W-1:0] OFF_FPH    = 8'h60;
  localparam logic [ADDR_W-1:0] OFF_FPL    = 8'h64;
endpackage

// File: rtl/vpic_regs.sv
// Configuration state; N_SRC is two bus words.
module vpic_regs
  import vpic_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int PRIO_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [N_SRC-1:0]        en_o,
  output logic [N_SRC-1:0]        typ_o,
  output logic [N_SRC-1:0]        frc_o,
  output logic [N_SRC*PRIO_W-1:0] prio_o,
  output logic [MASK_W-1:0]       mask_o,
  output logic                    prio_hit_o,
  output logic [DATA_W-1:0]       prio_rd_o
);
  localparam int IDX_W = $clog2(N_SRC);
  localparam int PER_W = DATA_W / PRIO_W;
  localparam int NGRP  = N_SRC / PER_W;
  localparam int GRP_W = $clog2(NGRP);

  logic [N_SRC-1:0]        en_q, typ_q, frc_q;
  logic [N_SRC*PRIO_W-1:0] prio_q;
  logic [MASK_W-1:0]       mask_q;
  logic [ADDR_W-1:0]       p_off;
  logic                    p_hit;
  logic [GRP_W-1:0]        grp;
  logic                    num_ok;
  logic [IDX_W-1:0]        widx;

  // priority groups are laid out in reverse order
  assign p_off  = addr_i - OFF_PRIO;
  assign p_hit  = (addr_i >= OFF_PRIO) && (p_off < ADDR_W'(4*NGRP)) && (addr_i[1:0] == 2'b00);
  assign grp    = GRP_W'(NGRP-1) - p_off[GRP_W+1:2];
  assign num_ok = wdata_i < DATA_W'(N_SRC);
  assign widx   = wdata_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      typ_q  <= '0;
      frc_q  <= '0;
      prio_q <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      if (p_hit) prio_q[grp*DATA_W +: DATA_W] <= wdata_i;
      case (addr_i)
        OFF_MASK:   mask_q <= wdata_i[MASK_W-1:0];
        OFF_ENNUM:  if (num_ok) en_q[widx] <= 1'b1;
        OFF_DISNUM: if (num_ok) en_q[widx] <= 1'b0;
        OFF_ENH:    en_q[DATA_W +: DATA_W]  <= wdata_i;
        OFF_ENL:    en_q[0 +: DATA_W]       <= wdata_i;
        OFF_TYPH:   typ_q[DATA_W +: DATA_W] <= wdata_i;
        OFF_TYPL:   typ_q[0 +: DATA_W]      <= wdata_i;
        OFF_FRCH:   frc_q[DATA_W +: DATA_W] <= wdata_i;
        OFF_FRCL:   frc_q[0 +: DATA_W]      <= wdata_i;
        default: ;
      endcase
    end
  end

  assign en_o       = en_q;
  assign typ_o      = typ_q;
  assign frc_o      = frc_q;
  assign prio_o     = prio_q;
  assign mask_o     = mask_q;
  assign prio_hit_o = p_hit;
  assign prio_rd_o  = prio_q[grp*DATA_W +: DATA_W];

  assert_ennum_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_ENNUM && num_ok) |=> en_q[$past(widx)]);
  assert_ennum_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_ENNUM && !num_ok) |=> $stable(en_q));
  assert_disnum_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_DISNUM && num_ok) |=> !en_q[$past(widx)]);
  assert_mask_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_MASK) |=> (mask_q == $past(wdata_i[MASK_W-1:0])));
endmodule

// File: rtl/vpic_norm_arb.sv
// Highest priority wins; ties go to the higher source number.
module vpic_norm_arb #(
  parameter int N_SRC  = 64,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    found_o,
  output logic [IDX_W-1:0]        id_o,
  output logic [PRIO_W-1:0]       lvl_o
);
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    lvl_o   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] >= lvl_o)) begin
        found_o = 1'b1;
        id_o    = IDX_W'(i);
        lvl_o   = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assert_nwin_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> pend_i[id_o]);
  assert_nwin_any_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend_i) |-> found_o);
endmodule

// File: rtl/vpic_fast_enc.sv
// Highest-numbered pending fast source.
module vpic_fast_enc #(
  parameter int N_SRC = 64,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] pend_i,
  output logic             found_o,
  output logic [IDX_W-1:0] id_o
);
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend_i[i]) begin
        found_o = 1'b1;
        id_o    = IDX_W'(i);
      end
    end
  end

  assert_fwin_top_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> ((pend_i >> id_o) == N_SRC'(1)));
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int PRIO_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  src_i,
  output logic              irq_norm_o,
  output logic              irq_fast_o
);
  localparam int IDX_W = $clog2(N_SRC);
  localparam int HALF  = DATA_W / 2;

  logic [N_SRC-1:0]        en, typ, frc, npend, fpend;
  logic [N_SRC*PRIO_W-1:0] prio;
  logic [MASK_W-1:0]       mask;
  logic                    prio_hit;
  logic [DATA_W-1:0]       prio_rd, nvec, fvec;
  logic                    n_found, f_found;
  logic [IDX_W-1:0]        n_id, f_id;
  logic [PRIO_W-1:0]       n_lvl;
  logic                    irq_norm_q, irq_fast_q;

  vpic_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .en_o(en), .typ_o(typ), .frc_o(frc), .prio_o(prio), .mask_o(mask),
    .prio_hit_o(prio_hit), .prio_rd_o(prio_rd)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic req, unmasked;
    assign req      = src_i[i] | frc[i];
    assign unmasked = mask[MASK_W-1] | (prio[i*PRIO_W +: PRIO_W] > mask[PRIO_W-1:0]);
    assign npend[i] = req & en[i] & ~typ[i] & unmasked;
    assign fpend[i] = req & en[i] & typ[i];
  end

  vpic_norm_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_narb (
    .clk_i, .rst_ni, .pend_i(npend), .prio_i(prio),
    .found_o(n_found), .id_o(n_id), .lvl_o(n_lvl)
  );

  vpic_fast_enc #(.N_SRC(N_SRC)) u_fenc (
    .clk_i, .rst_ni, .pend_i(fpend), .found_o(f_found), .id_o(f_id)
  );

  assign nvec = n_found ? {{(HALF-IDX_W){1'b0}}, n_id, {(HALF-PRIO_W){1'b0}}, n_lvl} : '1;
  assign fvec = f_found ? {{(HALF-IDX_W){1'b0}}, f_id, {HALF{1'b0}}} : '1;

  always_comb begin
    rdata_o = '0;
    if (prio_hit) rdata_o = prio_rd;
    case (addr_i)
      OFF_MASK: rdata_o = DATA_W'(mask);
      OFF_ENH:  rdata_o = en[DATA_W +: DATA_W];
      OFF_ENL:  rdata_o = en[0 +: DATA_W];
      OFF_TYPH: rdata_o = typ[DATA_W +: DATA_W];
      OFF_TYPL: rdata_o = typ[0 +: DATA_W];
      OFF_NVEC: rdata_o = nvec;
      OFF_FVEC: rdata_o = fvec;
      OFF_SRCH: rdata_o = src_i[DATA_W +: DATA_W];
      OFF_SRCL: rdata_o = src_i[0 +: DATA_W];
      OFF_FRCH: rdata_o = frc[DATA_W +: DATA_W];
      OFF_FRCL: rdata_o = frc[0 +: DATA_W];
      OFF_NPH:  rdata_o = npend[DATA_W +: DATA_W];
      OFF_NPL:  rdata_o = npend[0 +: DATA_W];
      OFF_FPH:  rdata_o = fpend[DATA_W +: DATA_W];
      OFF_FPL:  rdata_o = fpend[0 +: DATA_W];
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_norm_q <= 1'b0;
      irq_fast_q <= 1'b0;
    end else begin
      irq_norm_q <= |npend;
      irq_fast_q <= |fpend;
    end
  end

  assign irq_norm_o = irq_norm_q;
  assign irq_fast_o = irq_fast_q;

  assert_route_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((npend & fpend) == '0));
  assert_norm_rise_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|npend) |=> irq_norm_o);
  assert_norm_fall_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|npend) |=> !irq_norm_o);
  assert_fast_follow_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fpend) |=> irq_fast_o);
endmodule

// File: tb/vpic_top_test.sv
`timescale 1ns/1ps
module vpic_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src = '0;
  logic        irq_n, irq_f;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [63:0] m_en = '0, m_typ = '0, m_frc = '0;
  logic [3:0]  m_prio [64];
  logic [4:0]  m_mask = '0;

  always #2 clk = ~clk;

  vpic_top uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .src_i(src), .irq_norm_o(irq_n), .irq_fast_o(irq_f)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    case (a)
      8'h04: m_mask = d[4:0];
      8'h08: if (d < 64) m_en[d[5:0]] = 1'b1;
      8'h0C: if (d < 64) m_en[d[5:0]] = 1'b0;
      8'h10: m_en[63:32] = d;
      8'h14: m_en[31:0] = d;
      8'h18: m_typ[63:32] = d;
      8'h1C: m_typ[31:0] = d;
      8'h50: m_frc[63:32] = d;
      8'h54: m_frc[31:0] = d;
      default:
        if (a >= 8'h20 && a <= 8'h3C && a[1:0] == 2'b00) begin
          int g;
          g = 7 - int'((a - 8'h20) >> 2);
          for (int k = 0; k < 8; k++) m_prio[g*8+k] = d[4*k +: 4];
        end
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #0.5;
    v = rdata;
  endtask

  function automatic logic [63:0] exp_npend();
    logic [63:0] p;
    for (int i = 0; i < 64; i++)
      p[i] = (src[i] | m_frc[i]) & m_en[i] & ~m_typ[i] &
             (m_mask[4] | (m_prio[i] > m_mask[3:0]));
    return p;
  endfunction

  function automatic logic [63:0] exp_fpend();
    return (src | m_frc) & m_en & m_typ;
  endfunction

  function automatic logic [31:0] exp_nvec();
    logic [63:0] p;
    logic [31:0] v;
    int best;
    p = exp_npend();
    v = '1;
    best = -1;
    for (int i = 0; i < 64; i++)
      if (p[i] && (best < 0 || m_prio[i] >= m_prio[best])) best = i;
    if (best >= 0) v = {16'(best), 12'h0, m_prio[best]};
    return v;
  endfunction

  function automatic logic [31:0] exp_fvec();
    logic [63:0] p;
    logic [31:0] v;
    p = exp_fpend();
    v = '1;
    for (int i = 0; i < 64; i++) if (p[i]) v = {16'(i), 16'h0};
    return v;
  endfunction

  task automatic check_all();
    logic [31:0] v, e;
    logic [63:0] np, fp;
    np = exp_npend();
    fp = exp_fpend();
    rd(8'h10, v); chk("R4 enable high", v, m_en[63:32]);
    rd(8'h14, v); chk("R4 enable low", v, m_en[31:0]);
    rd(8'h18, v); chk("R5 type high", v, m_typ[63:32]);
    rd(8'h1C, v); chk("R5 type low", v, m_typ[31:0]);
    rd(8'h50, v); chk("R8 force high", v, m_frc[63:32]);
    rd(8'h54, v); chk("R8 force low", v, m_frc[31:0]);
    rd(8'h48, v); chk("R8 status high", v, src[63:32]);
    rd(8'h4C, v); chk("R8 status low", v, src[31:0]);
    rd(8'h04, v); chk("R7 mask", v, {27'h0, m_mask});
    for (int g = 0; g < 8; g++) begin
      for (int k = 0; k < 8; k++) e[4*k +: 4] = m_prio[g*8+k];
      rd(8'h20 + 8'(4*(7-g)), v); chk("R6 priority group", v, e);
    end
    rd(8'h58, v); chk("R9 normal pending high", v, np[63:32]);
    rd(8'h5C, v); chk("R9 normal pending low", v, np[31:0]);
    rd(8'h60, v); chk("R9 fast pending high", v, fp[63:32]);
    rd(8'h64, v); chk("R9 fast pending low", v, fp[31:0]);
    rd(8'h40, v); chk("R10 normal vector", v, exp_nvec());
    rd(8'h44, v); chk("R11 fast vector", v, exp_fvec());
    @(negedge clk);
    chk("R12 normal request", 32'(irq_n), 32'(|np));
    chk("R12 fast request", 32'(irq_f), 32'(|fp));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    for (int i = 0; i < 64; i++) m_prio[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(8'h14, v); chk("R1 enable low", v, 32'h0);
    rd(8'h3C, v); chk("R1 priority", v, 32'h0);
    rd(8'h40, v); chk("R1 normal vector", v, 32'hFFFF_FFFF);
    rd(8'h44, v); chk("R1 fast vector", v, 32'hFFFF_FFFF);
    chk("R1 outputs", {30'h0, irq_n, irq_f}, 32'h0);
    check_all();

    // R2 / R3: by-number enable and disable
    wr(8'h08, 32'd5);   rd(8'h14, v); chk("R2 set 5", v, 32'h0000_0020);
    wr(8'h08, 32'd40);  rd(8'h10, v); chk("R2 set 40", v, 32'h0000_0100);
    rd(8'h14, v); chk("R2 others kept", v, 32'h0000_0020);
    wr(8'h08, 32'd64);  rd(8'h14, v); chk("R2 range 64 low", v, 32'h0000_0020);
    rd(8'h10, v); chk("R2 range 64 high", v, 32'h0000_0100);
    wr(8'h08, 32'd100); rd(8'h14, v); chk("R2 range 100", v, 32'h0000_0020);
    wr(8'h0C, 32'd5);   rd(8'h14, v); chk("R3 clear 5", v, 32'h0);
    rd(8'h10, v); chk("R3 others kept", v, 32'h0000_0100);
    wr(8'h0C, 32'd40);

    // R6 / R10: packing and tie-break (group 0 lives at 0x3C)
    wr(8'h3C, 32'h5000_0005);
    wr(8'h08, 32'd0); wr(8'h08, 32'd7);
    @(negedge clk); src = 64'h81;
    rd(8'h40, v); chk("R10 tie higher number", v, 32'h0007_0005);
    wr(8'h20, 32'h9000_0000);
    wr(8'h08, 32'd63);
    @(negedge clk); src = 64'h8000_0000_0000_0081;
    rd(8'h40, v); chk("R6 R10 group 7 source 63", v, 32'h003F_0009);
    check_all();

    // R7: strict compare and override
    @(negedge clk); src = 64'h1;
    wr(8'h04, 32'd5); rd(8'h40, v); chk("R7 equal level masked", v, 32'hFFFF_FFFF);
    @(negedge clk); chk("R7 masked output", 32'(irq_n), 32'h0);
    wr(8'h04, 32'd4); rd(8'h40, v); chk("R7 below level passes", v, 32'h0000_0005);
    wr(8'h04, 32'd0); wr(8'h08, 32'd1); wr(8'h0C, 32'd0);
    @(negedge clk); src = 64'h2;
    rd(8'h40, v); chk("R7 priority 0 masked", v, 32'hFFFF_FFFF);
    wr(8'h04, 32'h10); rd(8'h40, v); chk("R7 bit4 override", v, 32'h0001_0000);
    check_all();

    // R8 / R5 / R11: force and fast routing
    @(negedge clk); src = '0;
    wr(8'h54, 32'h2); rd(8'h5C, v); chk("R8 force pends", v, 32'h2);
    rd(8'h4C, v); chk("R8 status raw", v, 32'h0);
    wr(8'h1C, 32'h2); rd(8'h44, v); chk("R5 R11 fast vector", v, 32'h0001_0000);
    rd(8'h5C, v); chk("R5 not normal", v, 32'h0);
    check_all();

    // random mix
    for (int it = 0; it < 150; it++) begin
      case ($urandom % 8)
        0: wr($urandom % 2 ? 8'h10 : 8'h14, $urandom);
        1: wr($urandom % 2 ? 8'h18 : 8'h1C, $urandom & $urandom);
        2: wr($urandom % 2 ? 8'h50 : 8'h54, $urandom & $urandom & $urandom);
        3: wr(8'h20 + 8'(4 * ($urandom % 8)), $urandom);
        4: wr(8'h04, $urandom % 32);
        5: wr($urandom % 2 ? 8'h08 : 8'h0C, $urandom % 72);
        default: begin
          @(negedge clk);
          src = {$urandom & $urandom, $urandom & $urandom};
        end
      endcase
      check_all();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule